// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single memory or I/O transfers on a bus whose low lines carry first the address and then the data. A request carries an address, write data, a direction bit, a memory-or-I/O bit and a two-bit segment code. Once accepted, the request is played out over four clock states. The first state puts the full address on the bus and pulses an address-latch enable so that an external latch can hold it. The middle two states carry the data phase and the active-low read or write strobe. The last state releases the strobes and, for reads, presents the captured data.

The state machine has five named states. ST_IDLE waits for a request. ST_T1 is the address phase. ST_T2 starts the data phase: the write data appears, or the low lines are released so that the target can drive them. ST_T3 is the state whose closing edge samples read data. ST_T4 releases the strobes. The transitions are IDLE->T1 (request present), IDLE->IDLE (no request), T1->T2, T2->T3, T3->T4 (always), T4->T1 (a new request is present, back-to-back) and T4->IDLE (no request). Besides the shared direction and memory-select outputs, four separately decoded active-low strobes are produced for memory read, memory write, I/O read and I/O write. From the second state on, the upper address lines carry the segment code instead of address bits.

Top module: `bus_cycle_seq`

## Requirements
- R1: An accepted cycle always walks ST_T1, ST_T2, ST_T3, ST_T4 on consecutive clocks. `req_ready` is high only in ST_IDLE and ST_T4, and a request made in ST_T1, ST_T2 or ST_T3 is ignored: the address, data and segment code on the bus do not change.
- R2: `addr_latch_en` is high exactly during ST_T1 and low in every other state.
- R3: `ad_oe` is high in ST_T1 with `ad_out` equal to address bits [15:0]. In ST_T2 to ST_T4, a write holds `ad_oe` high with `ad_out` equal to the write data, and a read holds `ad_oe` low. In ST_IDLE `ad_oe` is low.
- R4: `hi_out` (4 bits) carries address bits [19:16] in ST_T1. In ST_T2 to ST_T4 it carries the status value {2'b00, seg}, where seg is the request's 2-bit segment code (00 extra, 01 stack, 10 code, 11 data). `hi_oe` is high in ST_T1 to ST_T4 and low in ST_IDLE.
- R5: `rd_strobe_n` is low only in ST_T2 and ST_T3 of a read. `wr_strobe_n` is low only in ST_T2 and ST_T3 of a write. Both are high in ST_T1, ST_T4 and ST_IDLE.
- R6: `mem_sel` is 1 for a memory cycle (req_mem=1) and 0 for an I/O cycle through ST_T1 to ST_T4, and 0 in ST_IDLE. The four decoded strobes `memr_n`, `memw_n`, `ior_n` and `iow_n` are each the AND of the matching direction strobe with the matching memory/I/O selection. At most one of them is low at a time.
- R7: For a read, `rdata` takes the value of `ad_in` sampled at the clock edge that ends ST_T3. `rdata_valid` is high for the ST_T4 of a read only. Values present on `ad_in` in ST_T2 or ST_T4 are not captured.
- R8: A request present in ST_T4 starts its ST_T1 on the very next clock, with no idle state in between. With no request, ST_T4 returns to ST_IDLE.
- R9: After reset the block is in ST_IDLE with `req_ready`=1, `ad_oe`=0, `hi_oe`=0, `addr_latch_en`=0, `rdata_valid`=0 and all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A request is taken on this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment code shown as status |
| ad_out | output | 16 | Value driven on the multiplexed low lines |
| ad_oe | output | 1 | Output enable for the low lines |
| ad_in | input | 16 | Value sensed on the low lines |
| hi_out | output | 4 | Upper address bits, then status |
| hi_oe | output | 1 | Output enable for the upper lines |
| addr_latch_en | output | 1 | Address-latch enable pulse |
| mem_sel | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| memr_n | output | 1 | Active-low memory read |
| memw_n | output | 1 | Active-low memory write |
| ior_n | output | 1 | Active-low I/O read |
| iow_n | output | 1 | Active-low I/O write |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | Read data valid (ST_T4 of a read) |

## Verification
The bench sweeps every direction and space combination over several addresses and segment codes and checks each of the four states. It presents a correct value on `ad_in` only during ST_T3 and its complement in ST_T2 and ST_T4. A design that samples one state early or late then returns inverted data. Back-to-back pairs catch a sequencer that slips an idle state between cycles or loses the second request. Requests raised in mid-cycle catch a design that reloads its held request outside ST_IDLE or ST_T4, which would show up as a changed address or status on the bus. Strobe checks in ST_T1 and ST_T4 catch strobes that open early or release late, and checks of the low-line enable in read cycles catch a design that keeps driving the bus while the target answers.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } tstate_e;

    localparam int SEG_W = 2;

    function automatic logic in_data_phase(tstate_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_T4);
    endfunction

    function automatic logic in_strobe_phase(tstate_e s);
        return (s == ST_T2) || (s == ST_T3);
    endfunction

endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
    import bus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    output logic    req_ready,
    output logic    accept,
    output tstate_e state
);

    tstate_e state_d;

    always_comb begin
        req_ready = (state == ST_IDLE) || (state == ST_T4);
        accept    = req_ready && req_valid;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: state_d = req_valid ? ST_T1 : ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = ST_T4;
            ST_T4:   state_d = req_valid ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // R1: fixed four-state walk
    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);
    a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T2 |=> state == ST_T3);
    a_r1_t3_to_t4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T3 |=> state == ST_T4);
    // R8: back-to-back start
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4 && req_valid) |=> state == ST_T1);

endmodule

// File: rtl/bus_req_hold.sv
module bus_req_hold
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    output logic              h_write,
    output logic              h_mem,
    output logic [ADDR_W-1:0] h_addr,
    output logic [DATA_W-1:0] h_wdata,
    output logic [SEG_W-1:0]  h_seg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_write <= 1'b0;
            h_mem   <= 1'b0;
            h_addr  <= '0;
            h_wdata <= '0;
            h_seg   <= '0;
        end else if (accept) begin
            h_write <= req_write;
            h_mem   <= req_mem;
            h_addr  <= req_addr;
            h_wdata <= req_wdata;
            h_seg   <= req_seg;
        end
    end

    // R1: the held request changes only where a request may be taken
    a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(h_addr) && $stable(h_seg) && $stable(h_write));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  tstate_e state,
    input  logic    h_write,
    input  logic    h_mem,
    output logic    addr_latch_en,
    output logic    mem_sel,
    output logic    rd_strobe_n,
    output logic    wr_strobe_n,
    output logic    memr_n,
    output logic    memw_n,
    output logic    ior_n,
    output logic    iow_n
);

    logic active;

    always_comb begin
        active        = (state != ST_IDLE);
        addr_latch_en = (state == ST_T1);
        mem_sel       = active && h_mem;
        rd_strobe_n   = !(in_strobe_phase(state) && !h_write);
        wr_strobe_n   = !(in_strobe_phase(state) &&  h_write);
        memr_n        = rd_strobe_n || !mem_sel;
        memw_n        = wr_strobe_n || !mem_sel;
        ior_n         = rd_strobe_n ||  mem_sel;
        iow_n         = wr_strobe_n ||  mem_sel;
    end

    // R2: the latch enable is a single-state pulse
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_en |=> !addr_latch_en);
    // R5: strobes never open in the address phase
    a_r5_quiet_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_en |-> rd_strobe_n && wr_strobe_n);
    // R6: at most one decoded strobe at a time
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!memr_n, !memw_n, !ior_n, !iow_n}));

endmodule

// File: rtl/bus_ad_path.sv
module bus_ad_path
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  tstate_e                  state,
    input  logic                     h_write,
    input  logic [ADDR_W-1:0]        h_addr,
    input  logic [DATA_W-1:0]        h_wdata,
    input  logic [SEG_W-1:0]         h_seg,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     hi_oe,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] status_word;

    always_comb begin
        status_word            = '0;
        status_word[SEG_W-1:0] = h_seg;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        hi_out = '0;
        hi_oe  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ad_oe = 1'b0;
                hi_oe = 1'b0;
            end
            ST_T1: begin
                ad_out = h_addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                hi_out = h_addr[ADDR_W-1:DATA_W];
                hi_oe  = 1'b1;
            end
            ST_T2, ST_T3, ST_T4: begin
                ad_out = h_write ? h_wdata : '0;
                ad_oe  = h_write;
                hi_out = status_word;
                hi_oe  = 1'b1;
            end
            default: begin
                ad_oe = 1'b0;
                hi_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (state == ST_T3) && !h_write;
            if ((state == ST_T3) && !h_write) rdata <= ad_in;
        end
    end

    // R7: valid read data appears only after a read's sampling state
    a_r7_valid_after_t3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> state == ST_T4 && !h_write);
    a_r7_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_T3) |=> $stable(rdata));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_mem,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [1:0]               req_seg,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     hi_oe,
    output logic                     addr_latch_en,
    output logic                     mem_sel,
    output logic                     rd_strobe_n,
    output logic                     wr_strobe_n,
    output logic                     memr_n,
    output logic                     memw_n,
    output logic                     ior_n,
    output logic                     iow_n,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid
);

    tstate_e             state;
    logic                accept;
    logic                h_write;
    logic                h_mem;
    logic [ADDR_W-1:0]   h_addr;
    logic [DATA_W-1:0]   h_wdata;
    logic [SEG_W-1:0]    h_seg;

    bus_tstate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_ready(req_ready), .accept(accept), .state(state)
    );

    bus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_seg(req_seg),
        .h_write(h_write), .h_mem(h_mem), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_seg(h_seg)
    );

    bus_strobe_gen u_strb (
        .clk(clk), .rst_n(rst_n), .state(state),
        .h_write(h_write), .h_mem(h_mem),
        .addr_latch_en(addr_latch_en), .mem_sel(mem_sel),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n)
    );

    bus_ad_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ad (
        .clk(clk), .rst_n(rst_n), .state(state),
        .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_seg(h_seg),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .hi_out(hi_out), .hi_oe(hi_oe),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    // R3: the block never drives the low lines while its read strobe is open
    a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> !ad_oe);
    // R5: a write strobe always has data on the bus
    a_r5_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe_n |-> ad_oe && hi_oe);
    // R2: the address phase drives both halves of the address
    a_r2_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_en |-> ad_oe && hi_oe);

endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic [3:0]  hi_out;
    logic        hi_oe;
    logic        addr_latch_en, mem_sel, rd_strobe_n, wr_strobe_n;
    logic        memr_n, memw_n, ior_n, iow_n;
    logic [15:0] rdata;
    logic        rdata_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_seg(req_seg), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .hi_out(hi_out), .hi_oe(hi_oe),
        .addr_latch_en(addr_latch_en), .mem_sel(mem_sel),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mem_value(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    // strobes in order {rd, wr, memr, memw, ior, iow}, all active low
    function automatic logic [5:0] exp_strobes(input logic open, input logic w, input logic m);
        logic [5:0] s;
        s = 6'b111111;
        if (open) begin
            s[5] = w;
            s[4] = !w;
            s[3] = !(!w && m);
            s[2] = !(w && m);
            s[1] = !(!w && !m);
            s[0] = !(w && !m);
        end
        return s;
    endfunction

    function automatic logic [5:0] act_strobes();
        return {rd_strobe_n, wr_strobe_n, memr_n, memw_n, ior_n, iow_n};
    endfunction

    task automatic chk_idle(input string ctx);
        chk({"R1 ready idle ", ctx}, req_ready, 1);
        chk({"R2 ale idle ", ctx}, addr_latch_en, 0);
        chk({"R3 ad_oe idle ", ctx}, ad_oe, 0);
        chk({"R4 hi_oe idle ", ctx}, hi_oe, 0);
        chk({"R5 strobes idle ", ctx}, act_strobes(), 6'b111111);
        chk({"R6 mem_sel idle ", ctx}, mem_sel, 0);
        chk({"R7 rdata_valid idle ", ctx}, rdata_valid, 0);
    endtask

    // Called at a negedge where the block is in ST_IDLE or ST_T4.
    // Returns at the negedge inside ST_T4 of this cycle.
    task automatic run_cycle(input logic w, input logic m, input logic [19:0] a,
                             input logic [15:0] wd, input logic [1:0] sg,
                             input logic poke);
        logic [15:0] rv;
        rv = mem_value(a);
        chk("R1 ready before start", req_ready, 1);
        req_valid = 1'b1; req_write = w; req_mem = m;
        req_addr = a; req_wdata = wd; req_seg = sg;
        @(negedge clk); // ST_T1
        req_valid = 1'b0;
        ad_in = ~rv;
        chk("R1 ready T1", req_ready, 0);
        chk("R2 ale T1", addr_latch_en, 1);
        chk("R3 ad_oe T1", ad_oe, 1);
        chk("R3 ad_out addr T1", ad_out, a[15:0]);
        chk("R4 hi_out addr T1", hi_out, a[19:16]);
        chk("R4 hi_oe T1", hi_oe, 1);
        chk("R6 mem_sel T1", mem_sel, m);
        chk("R5 strobes T1", act_strobes(), 6'b111111);
        @(negedge clk); // ST_T2
        ad_in = ~rv;
        chk("R1 ready T2", req_ready, 0);
        chk("R2 ale T2", addr_latch_en, 0);
        chk("R3 ad_oe T2", ad_oe, w);
        if (w) chk("R3 wdata T2", ad_out, wd);
        chk("R4 status T2", hi_out, {2'b00, sg});
        chk("R6 mem_sel T2", mem_sel, m);
        chk("R5 R6 strobes T2", act_strobes(), exp_strobes(1'b1, w, m));
        if (poke) begin
            req_valid = 1'b1; req_write = !w; req_mem = !m;
            req_addr = ~a; req_wdata = ~wd; req_seg = ~sg;
        end
        @(negedge clk); // ST_T3
        req_valid = 1'b0;
        ad_in = rv;
        chk("R1 state T3 ale", addr_latch_en, 0);
        chk("R3 ad_oe T3", ad_oe, w);
        if (w) chk("R1 R3 wdata T3 unchanged", ad_out, wd);
        chk("R1 R4 status T3 unchanged", hi_out, {2'b00, sg});
        chk("R6 mem_sel T3", mem_sel, m);
        chk("R5 R6 strobes T3", act_strobes(), exp_strobes(1'b1, w, m));
        @(negedge clk); // ST_T4
        ad_in = ~rv;
        chk("R1 ready T4", req_ready, 1);
        chk("R2 ale T4", addr_latch_en, 0);
        chk("R3 ad_oe T4", ad_oe, w);
        if (w) chk("R3 wdata T4", ad_out, wd);
        chk("R4 status T4", hi_out, {2'b00, sg});
        chk("R5 strobes T4", act_strobes(), 6'b111111);
        chk("R6 mem_sel T4", mem_sel, m);
        chk("R7 rdata_valid T4", rdata_valid, !w);
        if (!w) chk("R7 rdata T3 sample", rdata, rv);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(negedge clk);
        chk_idle("after T4 (R8 return)");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // R9: reset state, including while a request is held
        req_valid = 1'b1;
        @(negedge clk);
        chk("R9 ready reset", req_ready, 1);
        chk("R9 ale reset", addr_latch_en, 0);
        chk("R9 ad_oe reset", ad_oe, 0);
        chk("R9 hi_oe reset", hi_oe, 0);
        chk("R9 strobes reset", act_strobes(), 6'b111111);
        chk("R9 rdata_valid reset", rdata_valid, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R9 after release");

        // sweep: all direction/space kinds, several addresses and segment codes
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 6; i++) begin
                logic [19:0] a;
                a = 20'(i * 20'h2D4B7 + k * 20'h1111 + 1);
                if (i == 4) a = 20'hFFFFF;
                if (i == 5) a = 20'h00000;
                run_cycle(k[1], k[0], a, 16'(a * 3 + 16'h0F0F), 2'(i + k), (i % 2) == 1);
                go_idle();
            end
        end

        // R8: back-to-back chains mixing kinds
        for (int n = 0; n < 8; n++) begin
            logic [19:0] a;
            a = 20'(n * 20'h13579 + 20'hABCDE);
            run_cycle(n[0], n[1], a, 16'(~a[15:0]), 2'(n), n[2]);
        end
        go_idle();
        // second chain: read after write after read at boundary addresses
        run_cycle(1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'b11, 1'b0);
        run_cycle(1'b1, 1'b0, 20'h00001, 16'hFFFF, 2'b00, 1'b1);
        run_cycle(1'b0, 1'b0, 20'h80000, 16'h1234, 2'b10, 1'b0);
        go_idle();
        repeat (2) @(negedge clk);
        chk_idle("final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule